// File: doc/BRIEF.md
# Multi-Engine Interrupt Status Controller

This block gathers interrupt causes from a set of copy engines and presents them to a host as one interrupt line. Each engine has its own six-bit status word. The causes are a copy-complete pulse, an error pulse, and four watermark causes. The watermark causes come from comparing the source ring occupancy and the destination ring occupancy against a high mark and a low mark held for each ring. A status bit latches when its cause occurs, whatever its enable says. It is cleared only by a write-one-to-clear access. A latched bit counts towards interrupting only when its enable is set.

Each ring has a small zone state machine with three states: `ZN_LOW` (occupancy below the low mark), `ZN_MID` (between the marks, inclusive) and `ZN_HIGH` (occupancy above the high mark). Reset puts it in `ZN_MID`. The transitions `ZN_LOW->ZN_HIGH` and `ZN_MID->ZN_HIGH` raise the high cause. The transitions `ZN_MID->ZN_LOW` and `ZN_HIGH->ZN_LOW` raise the low cause. The transitions `ZN_HIGH->ZN_MID` and `ZN_LOW->ZN_MID`, and staying in any state, raise nothing. The zone is recomputed every cycle, so a change of the marks can also cause a crossing.

A register port selects the engine with the upper address bits and the register with the low three bits. A summary register holds one bit per engine with an enabled pending cause. The interrupt output is a registered OR of that summary.

Top module: `eng_irq_ctrl`

## Requirements
- R1: After reset, every status word reads 0 and every enable reads 0. Each watermark register reads 0x001F0000 (high mark 31 in bits [20:16], low mark 0 in bits [4:0]). The summary and irq are 0.
- R2: A `cc_evt[i]` pulse sets status bit 0 of engine i at the clock edge that samples it, even when its enable is 0.
- R3: A ring's high cause is set when its occupancy goes from at most the high mark to strictly above it. Source sets status bit 1; destination sets status bit 3. Occupancy equal to the mark, or staying above it, sets nothing.
- R4: A ring's low cause is set when its occupancy goes from at least the low mark to strictly below it. Source sets status bit 2; destination sets status bit 4. Occupancy equal to the mark sets nothing.
- R5: An `err_evt[i]` pulse sets status bit 5. Only the miscellaneous enable (select 2, bit 0) enables it. The host enable (select 1, bits [4:0]) gates bits 0 to 4 only.
- R6: Writing select 0 clears exactly the status bits set in write data [5:0]. All other bits are kept.
- R7: When a cause and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `summary[i]` is 1 one cycle after engine i holds a status bit whose enable is set. Otherwise it is 0.
- R9: `irq` is 1 one cycle after any summary bit is 1, and 0 one cycle after all are 0.
- R10: Select 3 (source ring) and select 4 (destination ring) hold the watermarks: low mark at bit 0, high mark at bit 16. Both fields are written together and read back together.
- R11: Select 5 reads the summary bitmap, whatever engine index is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cc_evt | input | NUM_ENG | Copy-complete pulse per engine |
| err_evt | input | NUM_ENG | Error pulse per engine |
| src_occ | input | NUM_ENG*OCC_W | Source ring occupancy per engine |
| dst_occ | input | NUM_ENG*OCC_W | Destination ring occupancy per engine |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ENG_W+3 | {engine index, register select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| summary | output | NUM_ENG | Per-engine enabled-pending bitmap |
| irq | output | 1 | Combined interrupt |

## Verification
Occupancy is stepped onto each mark, just past it, held past it, and swung from one side straight to the other. This separates true crossings from level detection and from off-by-one compares. Pulses are given with enables off and then on. The error cause is enabled through the wrong register first, which shows that latching and gating are separate. Partial clear masks, and a clear that coincides with a new event, show bit independence and set priority. Activity on several engines, with one engine left idle, shows that the summary bits stay separate.

// File: rtl/eic_pkg.sv
`timescale 1ns/100ps
package eic_pkg;
    localparam int NC     = 6;
    localparam int SEL_W  = 3;
    localparam int WM_HI_LSB = 16;

    localparam int B_CC = 0;
    localparam int B_SH = 1;
    localparam int B_SL = 2;
    localparam int B_DH = 3;
    localparam int B_DL = 4;
    localparam int B_ER = 5;

    localparam logic [SEL_W-1:0] SEL_STAT = 3'd0;
    localparam logic [SEL_W-1:0] SEL_HIE  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MIE  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_SWM  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DWM  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_SUM  = 3'd5;

    typedef enum logic [1:0] {
        ZN_LOW  = 2'd0,
        ZN_MID  = 2'd1,
        ZN_HIGH = 2'd2
    } zone_e;
endpackage

// File: rtl/eic_wm_zone.sv
`timescale 1ns/100ps
module eic_wm_zone
    import eic_pkg::*;
#(
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lo_mark,
    input  logic [OCC_W-1:0] hi_mark,
    output logic             rise_hi,
    output logic             fall_lo
);
    zone_e zone_q, zone_d;

    always_comb begin
        if (occ > hi_mark)      zone_d = ZN_HIGH;
        else if (occ < lo_mark) zone_d = ZN_LOW;
        else                    zone_d = ZN_MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zone_q <= ZN_MID;
        else        zone_q <= zone_d;
    end

    always_comb begin
        rise_hi = 1'b0;
        fall_lo = 1'b0;
        unique case (zone_q)
            ZN_LOW:  rise_hi = (zone_d == ZN_HIGH);
            ZN_MID: begin
                rise_hi = (zone_d == ZN_HIGH);
                fall_lo = (zone_d == ZN_LOW);
            end
            ZN_HIGH: fall_lo = (zone_d == ZN_LOW);
            default: ;
        endcase
    end
endmodule

// File: rtl/eic_eng_regs.sv
`timescale 1ns/100ps
module eic_eng_regs
    import eic_pkg::*;
#(
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cc_evt,
    input  logic             err_evt,
    input  logic [OCC_W-1:0] src_occ,
    input  logic [OCC_W-1:0] dst_occ,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [31:0]      wdata,
    output logic [NC-1:0]    stat,
    output logic             pend,
    output logic [31:0]      rd_word
);
    localparam logic [OCC_W-1:0] MARK_MAX = '1;

    logic [NC-2:0]    hie_q;
    logic             mie_q;
    logic [OCC_W-1:0] s_lo_q, s_hi_q, d_lo_q, d_hi_q;
    logic             s_rise, s_fall, d_rise, d_fall;
    logic [NC-1:0]    set_v, clr_v;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;

    eic_wm_zone #(.OCC_W(OCC_W)) u_src_zone (
        .clk(clk), .rst_n(rst_n), .occ(src_occ),
        .lo_mark(s_lo_q), .hi_mark(s_hi_q),
        .rise_hi(s_rise), .fall_lo(s_fall)
    );

    eic_wm_zone #(.OCC_W(OCC_W)) u_dst_zone (
        .clk(clk), .rst_n(rst_n), .occ(dst_occ),
        .lo_mark(d_lo_q), .hi_mark(d_hi_q),
        .rise_hi(d_rise), .fall_lo(d_fall)
    );

    always_comb begin
        set_v       = '0;
        set_v[B_CC] = cc_evt;
        set_v[B_SH] = s_rise;
        set_v[B_SL] = s_fall;
        set_v[B_DH] = d_rise;
        set_v[B_DL] = d_fall;
        set_v[B_ER] = err_evt;
        clr_v = (wr_en && sel == SEL_STAT) ? wdata[NC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat   <= '0;
            hie_q  <= '0;
            mie_q  <= 1'b0;
            s_lo_q <= '0;
            s_hi_q <= MARK_MAX;
            d_lo_q <= '0;
            d_hi_q <= MARK_MAX;
        end else begin
            stat <= (stat & ~clr_v) | set_v;
            if (wr_en) begin
                unique case (sel)
                    SEL_HIE: hie_q <= wdata[NC-2:0];
                    SEL_MIE: mie_q <= wdata[0];
                    SEL_SWM: begin
                        s_lo_q <= wdata[OCC_W-1:0];
                        s_hi_q <= wdata[WM_HI_LSB +: OCC_W];
                    end
                    SEL_DWM: begin
                        d_lo_q <= wdata[OCC_W-1:0];
                        d_hi_q <= wdata[WM_HI_LSB +: OCC_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pend = |(stat & {mie_q, hie_q});

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_STAT: rd_word[NC-1:0] = stat;
            SEL_HIE:  rd_word[NC-2:0] = hie_q;
            SEL_MIE:  rd_word[0]      = mie_q;
            SEL_SWM: begin
                rd_word[OCC_W-1:0]             = s_lo_q;
                rd_word[WM_HI_LSB +: OCC_W]    = s_hi_q;
            end
            SEL_DWM: begin
                rd_word[OCC_W-1:0]             = d_lo_q;
                rd_word[WM_HI_LSB +: OCC_W]    = d_hi_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eng_irq_ctrl.sv
`timescale 1ns/100ps
module eng_irq_ctrl
    import eic_pkg::*;
#(
    parameter int  NUM_ENG = 4,
    parameter int  OCC_W   = 5,
    localparam int ENG_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
    localparam int ADDR_W  = ENG_W + SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ENG-1:0]       cc_evt,
    input  logic [NUM_ENG-1:0]       err_evt,
    input  logic [NUM_ENG*OCC_W-1:0] src_occ,
    input  logic [NUM_ENG*OCC_W-1:0] dst_occ,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NUM_ENG-1:0]       summary,
    output logic                     irq
);
    logic [ENG_W-1:0]        eng_idx;
    logic [SEL_W-1:0]        sel;
    logic [NUM_ENG-1:0]      pend_v;
    logic [NUM_ENG*NC-1:0]   stat_flat;
    logic [31:0]             rd_words [NUM_ENG];

    assign eng_idx = reg_addr[ADDR_W-1:SEL_W];
    assign sel     = reg_addr[SEL_W-1:0];

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        logic wr_hit;
        assign wr_hit = reg_wr && (eng_idx == ENG_W'(g));

        eic_eng_regs #(.OCC_W(OCC_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .cc_evt(cc_evt[g]), .err_evt(err_evt[g]),
            .src_occ(src_occ[g*OCC_W +: OCC_W]),
            .dst_occ(dst_occ[g*OCC_W +: OCC_W]),
            .wr_en(wr_hit), .sel(sel), .wdata(reg_wdata),
            .stat(stat_flat[g*NC +: NC]),
            .pend(pend_v[g]),
            .rd_word(rd_words[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            summary <= '0;
            irq     <= 1'b0;
        end else begin
            summary <= pend_v;
            irq     <= |summary;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_SUM) begin
            reg_rdata[NUM_ENG-1:0] = summary;
        end else begin
            for (int i = 0; i < NUM_ENG; i++) begin
                if (eng_idx == ENG_W'(i)) reg_rdata = rd_words[i];
            end
        end
    end
endmodule

// File: rtl/eng_irq_ctrl_chk.sv
`timescale 1ns/100ps
module eng_irq_ctrl_chk
    import eic_pkg::*;
#(
    parameter int  NUM_ENG = 4,
    localparam int ENG_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
    localparam int ADDR_W  = ENG_W + SEL_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_ENG-1:0]     cc_evt,
    input logic [NUM_ENG-1:0]     err_evt,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   wd0,
    input logic [NUM_ENG-1:0]     summary,
    input logic                   irq,
    input logic [NUM_ENG*NC-1:0]  stat_flat
);
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_chk
        // R2 and R7: a copy-complete pulse always leaves the bit set
        assert_cc_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cc_evt[g] |=> stat_flat[g*NC + B_CC]);

        assert_err_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
            err_evt[g] |=> stat_flat[g*NC + B_ER]);

        assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == {ENG_W'(g), SEL_STAT} && wd0 && !cc_evt[g])
            |=> !stat_flat[g*NC + B_CC]);

        assert_idle_no_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_flat[g*NC +: NC] == '0) |=> !summary[g]);
    end

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|summary) |=> irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|summary));
endmodule

bind eng_irq_ctrl eng_irq_ctrl_chk #(.NUM_ENG(NUM_ENG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cc_evt(cc_evt), .err_evt(err_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .wd0(reg_wdata[0]),
    .summary(summary), .irq(irq), .stat_flat(stat_flat)
);

// File: tb/eng_irq_ctrl_bench.sv
`timescale 1ns/100ps
module eng_irq_ctrl_bench;
    localparam int NE = 4;
    localparam int OW = 5;
    localparam int AW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NE-1:0]     cc_evt = '0;
    logic [NE-1:0]     err_evt = '0;
    logic [NE*OW-1:0]  src_occ = '0;
    logic [NE*OW-1:0]  dst_occ = '0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NE-1:0]     summary;
    logic              irq;

    eng_irq_ctrl #(.NUM_ENG(NE), .OCC_W(OW)) u_eng_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cc_evt(cc_evt), .err_evt(err_evt),
        .src_occ(src_occ), .dst_occ(dst_occ), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .summary(summary), .irq(irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       rid;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() > 0);
            #0.1;
            it = q.pop_front();
            if (it.kind == 0)      act = reg_rdata;
            else if (it.kind == 1) act = 32'(summary);
            else                   act = 32'(irq);
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.rid, act, it.exp);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int e, int sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'((e << 3) | sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(int e, int sel, logic [31:0] exp, string rid);
        reg_addr = AW'((e << 3) | sel);
        q.push_back('{0, exp, rid});
        #0.3;
    endtask

    task automatic chk_sum(logic [31:0] exp, string rid);
        q.push_back('{1, exp, rid});
        #0.3;
    endtask

    task automatic chk_irq(logic [31:0] exp, string rid);
        q.push_back('{2, exp, rid});
        #0.3;
    endtask

    task automatic pulse_cc(int e);
        @(negedge clk); cc_evt[e] = 1'b1;
        @(negedge clk); cc_evt[e] = 1'b0;
    endtask

    task automatic pulse_err(int e);
        @(negedge clk); err_evt[e] = 1'b1;
        @(negedge clk); err_evt[e] = 1'b0;
    endtask

    task automatic set_s(int e, int v);
        @(negedge clk); src_occ[e*OW +: OW] = OW'(v);
        @(negedge clk);
    endtask

    task automatic set_d(int e, int v);
        @(negedge clk); dst_occ[e*OW +: OW] = OW'(v);
        @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk_reg(0, 0, 32'h0, "R1 status");
        chk_reg(0, 1, 32'h0, "R1 host enable");
        chk_reg(0, 3, 32'h001F0000, "R1 src watermark");
        chk_reg(0, 4, 32'h001F0000, "R1 dst watermark");
        chk_sum(0, "R1 summary");
        step();
        chk_irq(0, "R1 irq");

        // R2 latch with enable off, R8 masked
        pulse_cc(0);
        chk_reg(0, 0, 32'h01, "R2 cc latched while disabled");
        step(2);
        chk_sum(0, "R8 masked cause gives no summary");
        chk_irq(0, "R9 no irq when summary clear");

        wr(0, 1, 32'h01);
        step();
        chk_sum(32'h1, "R8 enabled cause reaches summary");
        chk_irq(0, "R9 irq one cycle after summary");
        chk_reg(0, 5, 32'h1, "R11 summary register");
        step();
        chk_irq(1, "R9 irq asserted");

        // R10 watermark write/readback
        set_s(0, 8);
        wr(0, 3, (32'd10 << 16) | 32'd4);
        chk_reg(0, 3, 32'h000A0004, "R10 src watermark readback");

        // R3 high crossing
        set_s(0, 10);
        chk_reg(0, 0, 32'h01, "R3 equal to high mark does not fire");
        set_s(0, 11);
        chk_reg(0, 0, 32'h03, "R3 src high crossing");
        wr(0, 0, 32'h02);
        chk_reg(0, 0, 32'h01, "R6 clear src high only");
        step();
        chk_reg(0, 0, 32'h01, "R3 no refire while above");

        // R4 low crossing
        set_s(0, 4);
        chk_reg(0, 0, 32'h01, "R4 equal to low mark does not fire");
        set_s(0, 3);
        chk_reg(0, 0, 32'h05, "R4 src low crossing");
        set_s(0, 12);
        chk_reg(0, 0, 32'h07, "R3 jump from low zone to high zone");

        // R6 partial clear
        wr(0, 0, 32'h01);
        chk_reg(0, 0, 32'h06, "R6 cc cleared, watermarks kept");
        step();
        chk_sum(0, "R8 summary drops after clear");
        step();
        chk_irq(0, "R9 irq drops");

        // R7 set wins over clear
        @(negedge clk);
        cc_evt[0] = 1'b1; reg_wr = 1'b1; reg_addr = AW'(0); reg_wdata = 32'h01;
        @(negedge clk);
        cc_evt[0] = 1'b0; reg_wr = 1'b0;
        chk_reg(0, 0, 32'h07, "R7 set wins over clear");
        step();
        chk_sum(32'h1, "R7 summary after coinciding set");

        // R5 error gating on engine 2
        pulse_err(2);
        chk_reg(2, 0, 32'h20, "R5 error latched");
        wr(2, 1, 32'h1F);
        step();
        chk_sum(32'h1, "R5 host enable does not gate error");
        wr(2, 2, 32'h1);
        chk_reg(2, 2, 32'h1, "R5 misc enable readback");
        step();
        chk_sum(32'h5, "R5 misc enable gates error");
        chk_reg(3, 5, 32'h5, "R11 summary read via other engine index");
        chk_irq(1, "R9 irq with two engines pending");

        // destination ring on engine 3
        set_d(3, 3);
        wr(3, 4, (32'd5 << 16) | 32'd2);
        chk_reg(3, 4, 32'h00050002, "R10 dst watermark readback");
        set_d(3, 6);
        chk_reg(3, 0, 32'h08, "R3 dst high crossing");
        set_d(3, 1);
        chk_reg(3, 0, 32'h18, "R4 dst low crossing");
        chk_reg(1, 0, 32'h00, "R2 idle engine untouched");
        chk_sum(32'h5, "R8 disabled engine 3 not in summary");

        // clear everything
        wr(0, 0, 32'h3F);
        wr(2, 0, 32'h3F);
        wr(3, 0, 32'h3F);
        chk_reg(0, 0, 32'h0, "R6 full clear e0");
        chk_reg(2, 0, 32'h0, "R6 full clear e2");
        chk_reg(3, 0, 32'h0, "R6 full clear e3");
        step();
        chk_sum(0, "R8 summary clear");
        step();
        chk_irq(0, "R9 irq clear");

        step(2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            #200000;
        join_any
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule